// File: doc/BRIEF.md
# NOR Network Cost Evaluator

This block scores candidate logic networks for a hardware search engine. A candidate arrives as a chromosome: a bit vector that encodes a connection matrix for a feed-forward network of up to `NG` NOR gates over `NI` primary inputs. The block runs the encoded network on every row of a target truth table. It counts the rows on which the network output differs from the target and weights that count heavily. It then adds the network's own gate cost, derived from fan-in, and returns a single cost in which a lower value is better.

The evaluator is a fixed-latency pipeline with one register stage per truth-table row, followed by one summing stage. It accepts a new chromosome on every clock, and each result leaves in the same order its chromosome entered. A control input can complement the target for an individual chromosome, so a search can periodically flip its goal to keep the population diverse. A user tag travels with each chromosome and returns with its result.

Top module: `nor_cost_eval`

## Requirements
- R1: The chromosome is laid out column by column. Column k (gate k, k = 0..NG-1) starts at bit index k·NI + k(k-1)/2 and holds NI + k bits. Its first NI bits enable primary inputs 0..NI-1, and the next k bits enable the outputs of gates 0..k-1. The chromosome is NC = NI·NG + NG(NG-1)/2 bits wide (20 for NI=2, NG=5).
- R2: Each gate outputs the NOR of its enabled sources. A gate with no enabled source outputs 1. The network output is the output of gate NG-1.
- R3: For truth-table row r (0..2^NI-1), primary input j takes bit j of r. Bit r of the target word is the expected output for row r. When the invert input is 1, each expected bit is complemented.
- R4: Every row on which the network output differs from the expected output adds a penalty of NC + NG.
- R5: The intrinsic cost is the number of 1 bits in the chromosome plus the number of columns that contain at least one 1 bit.
- R6: The output cost is the sum of the penalty and the intrinsic cost. The output is wide enough to hold the largest value, (2^NI + 1)·(NC + NG), without wrapping.
- R7: A chromosome accepted with in_valid = 1 produces its result with out_valid = 1 exactly 2^NI + 1 clocks later. Back-to-back inputs give back-to-back results.
- R8: out_tag carries the in_tag value that was presented with the chromosome the result belongs to.
- R9: While rst_n is low, out_valid is 0.
- R10: A cycle with in_valid = 0 yields a cycle with out_valid = 0 at the corresponding output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Chromosome present this cycle |
| in_tag | input | TAG_W | User tag returned with the result |
| in_chrom | input | NC | Connection-matrix chromosome |
| in_target | input | 2^NI | Target truth table, bit r for row r |
| in_invert | input | 1 | Compare against the complemented target |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | TAG_W | Tag of the result |
| out_cost | output | COST_W | Combined cost |

## Verification
A corrupted penalty accumulator in any row stage shows up as a cost wrong by a multiple of NC + NG. This becomes visible 2^NI + 1 clocks after the chromosome enters, on the very next result of that chromosome. A misplaced column base or a wrong gate-source wiring changes either the row outcome or the column count, so chromosomes with a single set bit, whose expected costs are known exactly, expose it at once. A broken valid or tag chain shows a result in the wrong slot, or one with the wrong tag, and this is caught on each cycle of a random stream that contains bubbles.

// File: rtl/nor_eval_pkg.sv
package nor_eval_pkg;

    // First bit of gate k's column in the chromosome.
    function automatic int col_base(input int k, input int ni);
        return k * ni + (k * (k - 1)) / 2;
    endfunction

    function automatic int chrom_len(input int ni, input int ng);
        return ni * ng + (ng * (ng - 1)) / 2;
    endfunction

    // Width holding (rows + 1) * (nc + ng).
    function automatic int cost_width(input int ni, input int ng);
        int step;
        int rows;
        step = chrom_len(ni, ng) + ng;
        rows = 1 << ni;
        return $clog2((rows + 1) * step + 1);
    endfunction

endpackage

// File: rtl/nor_row_sim.sv
module nor_row_sim
    import nor_eval_pkg::*;
#(
    parameter int NI  = 2,
    parameter int NG  = 5,
    parameter int NC  = chrom_len(NI, NG),
    parameter int ROW = 0
) (
    input  logic [NC-1:0] chrom,
    output logic          net_out
);

    logic [NG-1:0] gate_q;

    for (genvar k = 0; k < NG; k++) begin : g_gate
        localparam int BASE = col_base(k, NI);
        logic [NI+k-1:0] en_src;

        for (genvar j = 0; j < NI; j++) begin : g_pin
            localparam bit PIN_VAL = ((ROW >> j) & 1) != 0;
            assign en_src[j] = chrom[BASE + j] & PIN_VAL;
        end

        for (genvar m = 0; m < k; m++) begin : g_fb
            assign en_src[NI + m] = chrom[BASE + NI + m] & gate_q[m];
        end

        assign gate_q[k] = ~(|en_src);
    end

    assign net_out = gate_q[NG-1];

endmodule

// File: rtl/nor_row_stage.sv
module nor_row_stage
    import nor_eval_pkg::*;
#(
    parameter int NI     = 2,
    parameter int NG     = 5,
    parameter int TAG_W  = 8,
    parameter int ROW    = 0,
    parameter int NC     = chrom_len(NI, NG),
    parameter int ROWS   = 1 << NI,
    parameter int COST_W = cost_width(NI, NG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [NC-1:0]     a_chrom,
    input  logic [ROWS-1:0]   a_expect,
    input  logic [COST_W-1:0] a_pen,
    output logic              z_valid,
    output logic [TAG_W-1:0]  z_tag,
    output logic [NC-1:0]     z_chrom,
    output logic [ROWS-1:0]   z_expect,
    output logic [COST_W-1:0] z_pen
);

    localparam int PEN_STEP = NC + NG;

    logic net_out;
    logic miss;
    logic [COST_W-1:0] pen_next;

    nor_row_sim #(.NI(NI), .NG(NG), .NC(NC), .ROW(ROW)) u_sim (
        .chrom   (a_chrom),
        .net_out (net_out)
    );

    always_comb begin
        miss     = net_out != a_expect[ROW];
        pen_next = a_pen;
        if (miss) begin
            pen_next = a_pen + COST_W'(PEN_STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_valid <= 1'b0;
        end else begin
            z_valid <= a_valid;
        end
    end

    always_ff @(posedge clk) begin
        z_tag    <= a_tag;
        z_chrom  <= a_chrom;
        z_expect <= a_expect;
        z_pen    <= pen_next;
    end

endmodule

// File: rtl/nor_intrinsic.sv
module nor_intrinsic
    import nor_eval_pkg::*;
#(
    parameter int NI     = 2,
    parameter int NG     = 5,
    parameter int NC     = chrom_len(NI, NG),
    parameter int COST_W = cost_width(NI, NG)
) (
    input  logic [NC-1:0]     chrom,
    output logic [COST_W-1:0] cost
);

    logic [NG-1:0] col_used;

    for (genvar k = 0; k < NG; k++) begin : g_col
        localparam int BASE = col_base(k, NI);
        assign col_used[k] = |chrom[BASE +: NI + k];
    end

    always_comb begin
        cost = '0;
        for (int b = 0; b < NC; b++) begin
            cost = cost + COST_W'(chrom[b]);
        end
        for (int k = 0; k < NG; k++) begin
            cost = cost + COST_W'(col_used[k]);
        end
    end

endmodule

// File: rtl/nor_cost_eval.sv
module nor_cost_eval
    import nor_eval_pkg::*;
#(
    parameter int NI     = 2,
    parameter int NG     = 5,
    parameter int TAG_W  = 8,
    parameter int NC     = chrom_len(NI, NG),
    parameter int ROWS   = 1 << NI,
    parameter int COST_W = cost_width(NI, NG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [NC-1:0]     in_chrom,
    input  logic [ROWS-1:0]   in_target,
    input  logic              in_invert,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [COST_W-1:0] out_cost
);

    logic              st_valid  [ROWS+1];
    logic [TAG_W-1:0]  st_tag    [ROWS+1];
    logic [NC-1:0]     st_chrom  [ROWS+1];
    logic [ROWS-1:0]   st_expect [ROWS+1];
    logic [COST_W-1:0] st_pen    [ROWS+1];

    assign st_valid[0]  = in_valid;
    assign st_tag[0]    = in_tag;
    assign st_chrom[0]  = in_chrom;
    assign st_expect[0] = in_target ^ {ROWS{in_invert}};
    assign st_pen[0]    = '0;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        nor_row_stage #(
            .NI(NI), .NG(NG), .TAG_W(TAG_W), .ROW(r),
            .NC(NC), .ROWS(ROWS), .COST_W(COST_W)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_valid  (st_valid[r]),
            .a_tag    (st_tag[r]),
            .a_chrom  (st_chrom[r]),
            .a_expect (st_expect[r]),
            .a_pen    (st_pen[r]),
            .z_valid  (st_valid[r+1]),
            .z_tag    (st_tag[r+1]),
            .z_chrom  (st_chrom[r+1]),
            .z_expect (st_expect[r+1]),
            .z_pen    (st_pen[r+1])
        );
    end

    logic [COST_W-1:0] own_cost;

    nor_intrinsic #(.NI(NI), .NG(NG), .NC(NC), .COST_W(COST_W)) u_intr (
        .chrom (st_chrom[ROWS]),
        .cost  (own_cost)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= st_valid[ROWS];
        end
    end

    always_ff @(posedge clk) begin
        out_tag  <= st_tag[ROWS];
        out_cost <= st_pen[ROWS] + own_cost;
    end

endmodule

// File: rtl/nor_cost_eval_chk.sv
module nor_cost_eval_chk
    import nor_eval_pkg::*;
#(
    parameter int NI     = 2,
    parameter int NG     = 5,
    parameter int TAG_W  = 8,
    parameter int NC     = chrom_len(NI, NG),
    parameter int COST_W = cost_width(NI, NG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [TAG_W-1:0]  in_tag,
    input logic [NC-1:0]     in_chrom,
    input logic              out_valid,
    input logic [TAG_W-1:0]  out_tag,
    input logic [COST_W-1:0] out_cost
);

    localparam int LAT  = (1 << NI) + 1;
    localparam int STEP = NC + NG;
    localparam int MAXC = LAT * STEP;

    logic [LAT-1:0]   v_sr;
    logic [LAT-1:0]   z_sr;
    logic [TAG_W-1:0] t_sr [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_sr <= '0;
        end else begin
            v_sr <= {v_sr[LAT-2:0], in_valid};
        end
    end

    always_ff @(posedge clk) begin
        z_sr    <= {z_sr[LAT-2:0], (in_chrom == '0)};
        t_sr[0] <= in_tag;
        for (int i = 1; i < LAT; i++) begin
            t_sr[i] <= t_sr[i-1];
        end
    end

    // R7, R10: result slot follows the accepted input by LAT clocks
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sr[LAT-1]);

    // R8
    p_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == t_sr[LAT-1]);

    // R6
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cost <= COST_W'(MAXC));

    // R2, R5: an empty network costs only whole penalties
    p_empty_net_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && z_sr[LAT-1]) |-> (int'(out_cost) % STEP) == 0);

endmodule

bind nor_cost_eval nor_cost_eval_chk #(
    .NI(NI), .NG(NG), .TAG_W(TAG_W), .NC(NC), .COST_W(COST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_chrom  (in_chrom),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_cost  (out_cost)
);

// File: tb/nor_cost_eval_tb.sv
module nor_cost_eval_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NI   = 2;
    localparam int NG   = 5;
    localparam int TW   = 8;
    localparam int NC   = NI * NG + (NG * (NG - 1)) / 2;
    localparam int ROWS = 1 << NI;
    localparam int CW   = $clog2((ROWS + 1) * (NC + NG) + 1);
    localparam int LAT  = ROWS + 1;
    localparam int STEP = NC + NG;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [TW-1:0]   in_tag = '0;
    logic [NC-1:0]   in_chrom = '0;
    logic [ROWS-1:0] in_target = '0;
    logic            in_invert = 1'b0;
    logic            out_valid;
    logic [TW-1:0]   out_tag;
    logic [CW-1:0]   out_cost;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    bit      ev [16];
    int      ec [16];
    int      et [16];
    string   er [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cost_eval #(.NI(NI), .NG(NG), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_chrom(in_chrom), .in_target(in_target), .in_invert(in_invert),
        .out_valid(out_valid), .out_tag(out_tag), .out_cost(out_cost)
    );

    function automatic int ref_cost(input logic [NC-1:0] c,
                                    input logic [ROWS-1:0] t, input bit inv);
        int pen = 0;
        int own = 0;
        for (int r = 0; r < ROWS; r++) begin
            bit g [NG];
            for (int k = 0; k < NG; k++) begin
                int base = k * NI + (k * (k - 1)) / 2;
                bit any = 1'b0;
                for (int j = 0; j < NI; j++)
                    if (c[base + j] && ((r >> j) & 1) == 1) any = 1'b1;
                for (int m = 0; m < k; m++)
                    if (c[base + NI + m] && g[m]) any = 1'b1;
                g[k] = !any;
            end
            if (g[NG-1] != (t[r] ^ inv)) pen += STEP;
        end
        for (int b = 0; b < NC; b++) own += int'(c[b]);
        for (int k = 0; k < NG; k++) begin
            int base = k * NI + (k * (k - 1)) / 2;
            bit used = 1'b0;
            for (int b = 0; b < NI + k; b++) if (c[base + b]) used = 1'b1;
            own += int'(used);
        end
        return pen + own;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: check the slot due now, then drive new inputs.
    task automatic step(input bit v, input logic [NC-1:0] c,
                        input logic [ROWS-1:0] t, input bit inv,
                        input string req);
        int s;
        int d;
        @(negedge clk);
        s = cyc % 16;
        check(out_valid == ev[s], ev[s] ? "R7" : "R10", "out_valid",
              int'(out_valid), int'(ev[s]));
        if (ev[s] && out_valid) begin
            check(int'(out_tag) == et[s], "R8", "out_tag", int'(out_tag), et[s]);
            check(int'(out_cost) == ec[s], er[s], "out_cost", int'(out_cost), ec[s]);
        end
        ev[s] = 1'b0;
        d = (cyc + LAT) % 16;
        in_valid  = v;
        in_tag    = TW'(cyc);
        in_chrom  = c;
        in_target = t;
        in_invert = inv;
        ev[d] = v;
        et[d] = cyc % 256;
        ec[d] = ref_cost(c, t, inv);
        er[d] = req;
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) ev[i] = 1'b0;
        // R9: out_valid stays low under reset even with valid input driven
        in_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R4: empty network outputs 1 on all rows
        step(1'b1, '0, 4'b0111, 1'b0, "R2 R4 empty");
        // R3: inversion flips which rows mismatch
        step(1'b1, '0, 4'b0111, 1'b1, "R3 invert");
        // R1 R3: only column 4, input 0 enabled -> out = !x0, matches 0101
        step(1'b1, NC'(1) << 14, 4'b0101, 1'b0, "R1 R3 column base");
        // R2: gate 4 fed only by empty gate 3 -> constant 0
        step(1'b1, NC'(1) << 19, 4'b0000, 1'b0, "R2 gate feed");
        // R5 R6: full matrix gives constant 0 output, all rows mismatch -> maximum
        step(1'b1, '1, 4'b1111, 1'b0, "R5 R6 max cost");
        step(1'b1, '1, 4'b0000, 1'b0, "R5 all ones");
        // R10: bubbles
        step(1'b0, '0, '0, 1'b0, "R10");
        step(1'b0, '0, '0, 1'b0, "R10");
        // R6 R4: odd parity and comparator-like random patterns
        step(1'b1, NC'(20'h5A3C1), 4'b0110, 1'b0, "R4 R6 parity");
        step(1'b1, NC'(20'h5A3C1), 4'b0110, 1'b1, "R4 R6 parity inv");

        for (int i = 0; i < 300; i++) begin
            bit v = ($urandom % 4) != 0;
            step(v, NC'($urandom), ROWS'($urandom), bit'($urandom % 2), "R4 R5 R6 random");
        end
        for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, 1'b0, "R10");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule